// File: doc/BRIEF.md
# CAN Controller Status and Error-State Tracker

This block keeps the status side of a CAN controller. A protocol engine feeds it bus events: a strobe with a 3-bit last-error code, TX-OK and RX-OK pulses, and requests to raise or lower the transmit and receive error counters. From the counters the block derives the warning, passive and bus-off states. It raises a status-interrupt request when an enabled class of status event occurs. It also reports which interrupt source has priority: a pending status event outranks any message-object number that the object store presents.

A host reaches four 16-bit registers through a plain read/write port with a 2-bit address. Reads return data combinationally. Address 0 is control, 1 is status, 2 is the error counters and 3 is the interrupt identifier. A read strobe on the status address acknowledges the pending status interrupt. The host can write the error-code value 7 as a marker. The marker stays in place until the engine reports a new bus event, so the host can tell whether a fresh event has arrived.

Top module: `can_err_tracker`

## Requirements
- R1: After reset, control reads 0x0001 (bit 0, INIT, set), and status, error counters and interrupt identifier read 0x0000. `irq` is low.
- R2: When `lec_vld` is high, `lec_code` is stored in status bits 2:0. The codes are 0 none, 1 stuff, 2 form, 3 acknowledge, 4 bit-1, 5 bit-0, 6 CRC, 7 marker. If the engine and the host update the field in the same cycle, the engine's code wins.
- R3: A host write to status stores write-data bits 2:0 in the error-code field. The stored value, for example the marker 7, is kept until the next `lec_vld`.
- R4: Status bit 3 (TX-OK) and bit 4 (RX-OK) are set by `tx_ok` and `rx_ok` pulses. A status write with the matching bit at 0 clears the flag, and a write with the bit at 1 leaves it alone. A set in the same cycle as a clear wins.
- R5: Register 2 holds the transmit count in bits 7:0, the receive count bits 6:0 in bits 14:8, and in bit 15 a flag that the receive count is 128 or more. `tec_inc` adds 8 and `tec_dec` subtracts 1, stopping at 0. `rec_inc` adds 1, stopping at 255, and `rec_dec` subtracts 1, stopping at 0. An increment beats a decrement of the same counter.
- R6: Status bit 6 (warning) is set while either count is 96 or more.
- R7: Status bit 5 (passive) is set while the transmit count is above 127 or the receive count is 128 or more.
- R8: A transmit increment that would pass 255 enters bus-off. Status bit 7 is set and the transmit count reads 255. While bus-off holds, all counter requests are ignored. INIT reads 1 from the next cycle on.
- R9: A control write with bit 0 at 0 during bus-off leaves bus-off and clears both counters.
- R10: Control bits 7:5 and 3:0 are writable. Bit 4 and bits 15:8 always read 0.
- R11: A status event sets the pending status interrupt. With control bit 2 set, the events are `tx_ok` and `rx_ok`. With control bit 3 set, the events are a change of status bit 5, 6 or 7, and a `lec_vld` with a code from 1 to 6. A status read with `reg_rd` clears the pending bit, unless a new event arrives in the same cycle.
- R12: The interrupt identifier reads 0x8000 while a status interrupt is pending. Otherwise it reads `obj_id` zero-extended, which is 0 when no object is pending.
- R13: `irq` equals control bit 1 ANDed with (status pending OR `obj_id` non-zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Host register address |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (acknowledges status on address 1) |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data |
| lec_vld | input | 1 | Engine error-code strobe |
| lec_code | input | 3 | Engine error code |
| tx_ok | input | 1 | Frame sent successfully |
| rx_ok | input | 1 | Frame received successfully |
| tec_inc | input | 1 | Raise transmit error count by 8 |
| tec_dec | input | 1 | Lower transmit error count by 1 |
| rec_inc | input | 1 | Raise receive error count by 1 |
| rec_dec | input | 1 | Lower receive error count by 1 |
| obj_id | input | 6 | Number of the pending message object, 0 if none |
| irq | output | 1 | Interrupt request |
| ctrl | output | 8 | Control register contents |

## Verification
The bench aims at the edges of the error counters. It checks the warning threshold at exactly 96, the passive threshold at 128, and the bus-off step from 248. A design that compared with the wrong bound, or let the counter wrap, would show flags one step late or would never enter bus-off. The bench also checks that counter requests are ignored during bus-off and that writing INIT to 0 recovers from it. Further checks cover the marker value surviving idle cycles, an event beating a host clear in the same cycle, the status priority over object numbers, and the gating of `irq` by the module enable. A design that got these wrong would let the host miss events or raise interrupts that are masked.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;
  localparam int REG_AW = 2;
  localparam int REG_DW = 16;
  localparam logic [REG_AW-1:0] ADR_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] ADR_STAT = 2'd1;
  localparam logic [REG_AW-1:0] ADR_ECNT = 2'd2;
  localparam logic [REG_AW-1:0] ADR_IID  = 2'd3;
  localparam logic [7:0] CTRL_WMASK = 8'hEF;
  localparam logic [REG_DW-1:0] IID_STATUS = 16'h8000;

  typedef enum logic [2:0] {
    LEC_NONE  = 3'd0,
    LEC_STUFF = 3'd1,
    LEC_FORM  = 3'd2,
    LEC_ACK   = 3'd3,
    LEC_BIT1  = 3'd4,
    LEC_BIT0  = 3'd5,
    LEC_CRC   = 3'd6,
    LEC_MARK  = 3'd7
  } lec_e;

  typedef struct packed {
    logic boff;
    logic warn;
    logic pass;
  } err_flags_t;
endpackage

// File: rtl/can_err_counters.sv
module can_err_counters
  import can_stat_pkg::*;
#(
  parameter int CW       = 8,
  parameter int TEC_STEP = 8,
  parameter int WARN_LVL = 96,
  parameter int PASS_LVL = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tec_inc,
  input  logic          tec_dec,
  input  logic          rec_inc,
  input  logic          rec_dec,
  input  logic          recover,
  output logic [CW-1:0] tec,
  output logic [CW-1:0] rec,
  output logic          rec_pass,
  output err_flags_t    flags
);
  localparam logic [CW-1:0] WARN_V = CW'(WARN_LVL);
  localparam logic [CW-1:0] PASS_V = CW'(PASS_LVL);
  localparam logic [CW:0]   STEP_V = (CW+1)'(TEC_STEP);
  localparam logic [CW-1:0] MAX_V  = {CW{1'b1}};

  logic [CW-1:0] tec_q, tec_d, rec_q, rec_d;
  logic          boff_q, boff_d;
  logic [CW:0]   tec_sum;

  always_comb begin
    tec_d   = tec_q;
    rec_d   = rec_q;
    boff_d  = boff_q;
    tec_sum = {1'b0, tec_q} + STEP_V;
    if (recover) begin
      tec_d  = '0;
      rec_d  = '0;
      boff_d = 1'b0;
    end else if (!boff_q) begin
      if (tec_inc) begin
        if (tec_sum[CW]) begin
          tec_d  = MAX_V;
          boff_d = 1'b1;
        end else begin
          tec_d = tec_sum[CW-1:0];
        end
      end else if (tec_dec && tec_q != '0) begin
        tec_d = tec_q - 1'b1;
      end
      if (rec_inc) begin
        if (rec_q != MAX_V) rec_d = rec_q + 1'b1;
      end else if (rec_dec && rec_q != '0) begin
        rec_d = rec_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec_q  <= '0;
      rec_q  <= '0;
      boff_q <= 1'b0;
    end else begin
      tec_q  <= tec_d;
      rec_q  <= rec_d;
      boff_q <= boff_d;
    end
  end

  assign tec        = tec_q;
  assign rec        = rec_q;
  assign rec_pass   = (rec_q >= PASS_V);
  assign flags.boff = boff_q;
  assign flags.warn = (tec_q >= WARN_V) || (rec_q >= WARN_V);
  assign flags.pass = (tec_q >= PASS_V) || (rec_q >= PASS_V);

  // R5: the transmit count stops at zero
  a_r5_tec_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (!boff_q && !recover && tec_dec && !tec_inc && tec_q == '0) |=> (tec_q == '0));

  // R8: counters are frozen during bus-off
  a_r8_boff_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (boff_q && !recover) |=> (boff_q && $stable(tec_q) && $stable(rec_q)));
endmodule

// File: rtl/can_stat_reg.sv
module can_stat_reg
  import can_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lec_vld,
  input  logic [2:0]        lec_code,
  input  logic              tx_ok,
  input  logic              rx_ok,
  input  logic              wr_stat,
  input  logic              rd_stat,
  input  logic [REG_DW-1:0] wdata,
  input  err_flags_t        flags,
  input  logic              sie,
  input  logic              eie,
  output logic [REG_DW-1:0] stat,
  output logic              pend
);
  logic [2:0] lec_q, lec_d;
  logic       txok_q, txok_d, rxok_q, rxok_d;
  logic       pend_q, pend_d;
  err_flags_t prev_q;
  logic       lec_err, flag_chg, ev;

  always_comb begin
    lec_err  = lec_vld && (lec_code != LEC_NONE) && (lec_code != LEC_MARK);
    flag_chg = (flags != prev_q);
    ev       = (sie && (tx_ok || rx_ok)) || (eie && (flag_chg || lec_err));
    pend_d   = ev || (pend_q && !rd_stat);
    if (lec_vld)      lec_d = lec_code;
    else if (wr_stat) lec_d = wdata[2:0];
    else              lec_d = lec_q;
    txok_d = tx_ok || (txok_q && !(wr_stat && !wdata[3]));
    rxok_d = rx_ok || (rxok_q && !(wr_stat && !wdata[4]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lec_q  <= LEC_NONE;
      txok_q <= 1'b0;
      rxok_q <= 1'b0;
      pend_q <= 1'b0;
      prev_q <= '0;
    end else begin
      lec_q  <= lec_d;
      txok_q <= txok_d;
      rxok_q <= rxok_d;
      pend_q <= pend_d;
      prev_q <= flags;
    end
  end

  assign stat = {8'h00, flags.boff, flags.warn, flags.pass, rxok_q, txok_q, lec_q};
  assign pend = pend_q;

  // R3: the error code holds without an engine or host update
  a_r3_lec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!lec_vld && !wr_stat) |=> $stable(lec_q));

  // R4: a TX-OK pulse always sets the flag
  a_r4_txok_set: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ok |=> txok_q);

  // R11: pending holds until acknowledged
  a_r11_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !rd_stat) |=> pend_q);
endmodule

// File: rtl/can_irq_ident.sv
module can_irq_ident
  import can_stat_pkg::*;
#(
  parameter int OBJ_W = 6
) (
  input  logic              pend,
  input  logic [OBJ_W-1:0]  obj_id,
  input  logic              ie,
  output logic [REG_DW-1:0] iid,
  output logic              irq
);
  logic obj_any;

  always_comb begin
    obj_any = (obj_id != '0);
    if (pend) iid = IID_STATUS;
    else      iid = REG_DW'(obj_id);
    irq = ie && (pend || obj_any);
  end
endmodule

// File: rtl/can_err_tracker.sv
module can_err_tracker
  import can_stat_pkg::*;
#(
  parameter int OBJ_W    = 6,
  parameter int CW       = 8,
  parameter int TEC_STEP = 8,
  parameter int WARN_LVL = 96,
  parameter int PASS_LVL = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              lec_vld,
  input  logic [2:0]        lec_code,
  input  logic              tx_ok,
  input  logic              rx_ok,
  input  logic              tec_inc,
  input  logic              tec_dec,
  input  logic              rec_inc,
  input  logic              rec_dec,
  input  logic [OBJ_W-1:0]  obj_id,
  output logic              irq,
  output logic [7:0]        ctrl
);
  logic [7:0]        ctrl_q, ctrl_d;
  logic              wr_ctrl, wr_stat, rd_stat, recover;
  logic [CW-1:0]     tec, rec;
  logic              rec_pass, pend;
  err_flags_t        flags;
  logic [REG_DW-1:0] stat, iid;

  assign wr_ctrl = reg_wr && (reg_addr == ADR_CTRL);
  assign wr_stat = reg_wr && (reg_addr == ADR_STAT);
  assign rd_stat = reg_rd && (reg_addr == ADR_STAT);
  assign recover = wr_ctrl && !reg_wdata[0] && flags.boff;

  can_err_counters #(
    .CW(CW), .TEC_STEP(TEC_STEP), .WARN_LVL(WARN_LVL), .PASS_LVL(PASS_LVL)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .tec_inc(tec_inc), .tec_dec(tec_dec),
    .rec_inc(rec_inc), .rec_dec(rec_dec),
    .recover(recover),
    .tec(tec), .rec(rec), .rec_pass(rec_pass), .flags(flags)
  );

  can_stat_reg u_stat (
    .clk(clk), .rst_n(rst_n),
    .lec_vld(lec_vld), .lec_code(lec_code),
    .tx_ok(tx_ok), .rx_ok(rx_ok),
    .wr_stat(wr_stat), .rd_stat(rd_stat), .wdata(reg_wdata),
    .flags(flags), .sie(ctrl_q[2]), .eie(ctrl_q[3]),
    .stat(stat), .pend(pend)
  );

  can_irq_ident #(.OBJ_W(OBJ_W)) u_iid (
    .pend(pend), .obj_id(obj_id), .ie(ctrl_q[1]),
    .iid(iid), .irq(irq)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = reg_wdata[7:0] & CTRL_WMASK;
    if (flags.boff && !recover) ctrl_d[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= 8'h01;
    else        ctrl_q <= ctrl_d;
  end

  always_comb begin
    case (reg_addr)
      ADR_CTRL: reg_rdata = {8'h00, ctrl_q};
      ADR_STAT: reg_rdata = stat;
      ADR_ECNT: reg_rdata = {rec_pass, rec[6:0], tec[7:0]};
      default:  reg_rdata = iid;
    endcase
  end

  assign ctrl = ctrl_q;

  // R8: bus-off forces INIT by the next cycle
  a_r8_boff_init: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.boff && !recover) |=> ctrl_q[0]);

  // R13: no interrupt while the module enable is clear
  a_r13_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[1] |-> !irq);

  // R10: bit 4 of control never set
  a_r10_ctrl_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[4]);
endmodule

// File: tb/can_err_tracker_bench.sv
module can_err_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [15:0] reg_wdata, reg_rdata;
  logic        lec_vld;
  logic [2:0]  lec_code;
  logic        tx_ok, rx_ok, tec_inc, tec_dec, rec_inc, rec_dec;
  logic [5:0]  obj_id;
  logic        irq;
  logic [7:0]  ctrl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  can_err_tracker u_can_err_tracker (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lec_vld(lec_vld), .lec_code(lec_code), .tx_ok(tx_ok), .rx_ok(rx_ok),
    .tec_inc(tec_inc), .tec_dec(tec_dec), .rec_inc(rec_inc), .rec_dec(rec_dec),
    .obj_id(obj_id), .irq(irq), .ctrl(ctrl)
  );

  // {expected pending, code}
  localparam logic [3:0] LEC_TAB [8] = '{
    4'b1_011, 4'b0_000, 4'b1_110, 4'b0_111,
    4'b1_001, 4'b1_101, 4'b1_010, 4'b1_100
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_addr = 0; reg_wr = 0; reg_rd = 0; reg_wdata = 0;
    lec_vld = 0; lec_code = 0; tx_ok = 0; rx_ok = 0;
    tec_inc = 0; tec_dec = 0; rec_inc = 0; rec_dec = 0; obj_id = 0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic lec_evt(input logic [2:0] c);
    lec_vld = 1'b1; lec_code = c;
    @(negedge clk);
    lec_vld = 1'b0;
  endtask

  task automatic tinc(input int n);
    for (int i = 0; i < n; i++) begin
      tec_inc = 1'b1; @(negedge clk); tec_inc = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    do_reset();
    // R1 reset values
    peek(2'd0, v); chk("R1 ctrl", v, 16'h0001);
    peek(2'd1, v); chk("R1 status", v, 16'h0000);
    peek(2'd2, v); chk("R1 errcnt", v, 16'h0000);
    peek(2'd3, v); chk("R1 intid", v, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);

    // R10 reserved control bit
    wr(2'd0, 16'hFFFF);
    peek(2'd0, v); chk("R10 ctrl mask", v, 16'h00EF);

    // R2/R11 table of error codes with error enable
    do_reset();
    wr(2'd0, 16'h0008);
    for (int i = 0; i < 8; i++) begin
      lec_evt(LEC_TAB[i][2:0]);
      peek(2'd3, v); chk("R11 lec pending", v, LEC_TAB[i][3] ? 16'h8000 : 16'h0000);
      rd(2'd1, v);   chk("R2 lec stored", {13'd0, v[2:0]}, {13'd0, LEC_TAB[i][2:0]});
      peek(2'd3, v); chk("R11 ack", v, 16'h0000);
    end
    // R2 engine wins over host write
    reg_addr = 2'd1; reg_wdata = 16'h0007; reg_wr = 1'b1; lec_vld = 1'b1; lec_code = 3'd5;
    @(negedge clk); reg_wr = 1'b0; lec_vld = 1'b0;
    peek(2'd1, v); chk("R2 engine wins", {13'd0, v[2:0]}, 16'h0005);

    // R3/R4
    do_reset();
    tx_ok = 1; rx_ok = 1; @(negedge clk); tx_ok = 0; rx_ok = 0;
    peek(2'd1, v); chk("R4 ok set", v, 16'h0018);
    wr(2'd1, 16'h0010);
    peek(2'd1, v); chk("R4 clear tx only", v, 16'h0010);
    wr(2'd1, 16'h0007);
    idle(5);
    peek(2'd1, v); chk("R3 marker held", v, 16'h0007);
    lec_evt(3'd3);
    peek(2'd1, v); chk("R3 marker replaced", v, 16'h0003);
    reg_addr = 2'd1; reg_wdata = 16'h0000; reg_wr = 1'b1; tx_ok = 1'b1;
    @(negedge clk); reg_wr = 1'b0; tx_ok = 1'b0;
    peek(2'd1, v); chk("R4 set beats clear", v, 16'h0008);

    // R5/R6/R7/R11 transmit counter thresholds
    do_reset();
    wr(2'd0, 16'h0008);
    tinc(11);
    peek(2'd1, v); chk("R6 below warn", v, 16'h0000);
    peek(2'd2, v); chk("R5 tec 88", v, 16'h0058);
    tinc(1); idle(1);
    peek(2'd1, v); chk("R6 warn at 96", v, 16'h0040);
    peek(2'd3, v); chk("R11 flag change pending", v, 16'h8000);
    tinc(4);
    peek(2'd1, v); chk("R7 passive at 128", v, 16'h0060);
    tec_inc = 1; tec_dec = 1; @(negedge clk); tec_inc = 0; tec_dec = 0;
    peek(2'd2, v); chk("R5 inc beats dec", v, 16'h0088);
    tec_dec = 1; @(negedge clk); tec_dec = 0;
    peek(2'd2, v); chk("R5 dec", v, 16'h0087);

    // R5/R7 receive counter
    do_reset();
    rec_dec = 1; @(negedge clk); rec_dec = 0;
    peek(2'd2, v); chk("R5 rec floor", v, 16'h0000);
    for (int i = 0; i < 128; i++) begin
      rec_inc = 1; @(negedge clk); rec_inc = 0;
    end
    peek(2'd2, v); chk("R5 rec passive flag", v, 16'h8000);
    peek(2'd1, v); chk("R7 rec passive", v, 16'h0060);

    // R8/R9 bus-off and recovery
    do_reset();
    wr(2'd0, 16'h0000);
    tinc(31);
    peek(2'd2, v); chk("R8 tec 248", v, 16'h00F8);
    peek(2'd1, v); chk("R8 not yet off", v, 16'h0060);
    tinc(1); idle(1);
    peek(2'd1, v); chk("R8 bus-off", v, 16'h00E0);
    peek(2'd2, v); chk("R8 tec max", v, 16'h00FF);
    peek(2'd0, v); chk("R8 init forced", v, 16'h0001);
    tec_dec = 1; rec_inc = 1; @(negedge clk); tec_dec = 0; rec_inc = 0;
    peek(2'd2, v); chk("R8 requests ignored", v, 16'h00FF);
    wr(2'd0, 16'h0001);
    peek(2'd1, v); chk("R9 init=1 keeps bus-off", v, 16'h00E0);
    wr(2'd0, 16'h0000);
    peek(2'd2, v); chk("R9 counters cleared", v, 16'h0000);
    peek(2'd1, v); chk("R9 bus-off left", v, 16'h0000);
    peek(2'd0, v); chk("R9 ctrl", v, 16'h0000);

    // R11/R12/R13 identifier priority and gating
    do_reset();
    wr(2'd0, 16'h0002);
    tx_ok = 1; @(negedge clk); tx_ok = 0;
    peek(2'd3, v); chk("R11 sie off no pending", v, 16'h0000);
    wr(2'd0, 16'h0006);
    obj_id = 6'd5;
    tx_ok = 1; @(negedge clk); tx_ok = 0;
    peek(2'd3, v); chk("R12 status first", v, 16'h8000);
    chk("R13 irq on", {15'd0, irq}, 16'h0001);
    rd(2'd1, v);
    peek(2'd3, v); chk("R12 object id", v, 16'h0005);
    chk("R13 irq object", {15'd0, irq}, 16'h0001);
    obj_id = 6'd0; #1;
    peek(2'd3, v); chk("R12 none", v, 16'h0000);
    chk("R13 irq off", {15'd0, irq}, 16'h0000);
    wr(2'd0, 16'h0004);
    rx_ok = 1; @(negedge clk); rx_ok = 0;
    peek(2'd3, v); chk("R11 rx pending", v, 16'h8000);
    chk("R13 gated", {15'd0, irq}, 16'h0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule